// File: doc/BRIEF.md
# ADC Convert-Start and Power-Down Sequencer

This block holds the digital timing and control of a sampling converter that has a single convert-start pin. A rising edge on the pin is taken as a wake-up request. It launches an internal power-up window that lasts a fixed number of clock cycles. The pin and that window are combined by a logical OR. The conversion begins once both have dropped, so whichever of the two ends later sets the sampling instant.

When the analog core reports completion, the block clears its busy flag and captures the core's result in an output register. The register stays readable at all times. At that same moment it samples the pin. A high pin keeps the converter powered for back-to-back high-rate conversions. A low pin puts it into power-down, and the next rising edge of the pin wakes it again. The pin is asynchronous and passes through a two-stage synchroniser first. The successive-approximation core is outside this block. The bench provides a behavioural completion strobe in its place.

Top module: `adc_start_sequencer`

## Requirements
- R1: After reset, `busy_o`, `hold_o` and `pwrdn_o` are 0 and `result_o` is all zeros.
- R2: A rising edge on `convst_i` starts a power-up window of `PULSE_CYCLES` cycles. If the pin is high for W clock edges with W <= `PULSE_CYCLES`, `busy_o` rises on clock edge `PULSE_CYCLES`+4, counting the first edge after the pin rose as edge 1.
- R3: If the pin stays high for W > `PULSE_CYCLES` edges, the later pin fall governs, and `busy_o` rises on edge W+3.
- R4: `hold_o` is high for exactly one cycle, which is the first cycle in which `busy_o` is high.
- R5: On the clock edge that samples `conv_done_i` high while busy, `busy_o` falls and `result_o` takes the value of `core_result_i`.
- R6: If the synchronised pin is high when `busy_o` falls, `pwrdn_o` stays 0.
- R7: If the synchronised pin is low when `busy_o` falls, `pwrdn_o` becomes 1 on that edge.
- R8: In power-down, a rising pin edge clears `pwrdn_o` on edge 3 after the pin rose. That edge also launches a conversion with the timing of R2 and R3.
- R9: `result_o` changes only when a conversion ends. A `conv_done_i` pulse while not busy has no effect, and the value holds through power-down.
- R10: A rising pin edge while `busy_o` is high is ignored. The running conversion finishes normally, and no new conversion follows it.
- R11: A falling pin edge without a preceding accepted rising edge does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| convst_i | input | 1 | Asynchronous convert-start pin |
| conv_done_i | input | 1 | One-cycle completion strobe from the analog core |
| core_result_i | input | RES_W | Conversion value from the analog core |
| hold_o | output | 1 | One-cycle strobe: sampler enters hold, conversion begins |
| busy_o | output | 1 | Conversion in progress |
| pwrdn_o | output | 1 | Converter in power-down |
| result_o | output | RES_W | Latched conversion result |

## Verification
The pin reaches the control logic two edges after it changes, and a launch registers on the third edge. `busy_o` and `hold_o` then rise one edge after the later of the synchronised pin fall and the end of the window, which gives max(W, `PULSE_CYCLES`+1)+3 edges. The bench counts edges from the one after the pin is driven, and compares the count of the first busy sample with that formula. `busy_o`, `result_o` and `pwrdn_o` respond to a completion strobe on the very next edge. The bench therefore drives inputs on falling edges and samples every output at the following falling edge. It holds the pin steady for at least four cycles before a completion, so the mode decision sees a settled level.

// File: rtl/adc_seq_pkg.sv
// Shared types of the convert-start sequencer.
// Assumes nothing beyond the IEEE 1800-2017 type system.
package adc_seq_pkg;

    // Controller states: waiting for a launch, launched and waiting for the
    // combined start signal to drop, and converting.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pin_sync.sv
// Synchronises the asynchronous convert-start pin into the clock domain
// through a chain of STAGES flops. Provides the settled level and a one-cycle
// rising-edge flag derived from it.
// Assumes STAGES >= 2 and a synchronous active-low reset that clears the
// chain, so a pin held high across reset appears as a rising edge.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              level_d_q;

    // Shift the pin through the synchroniser chain.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d_q <= 1'b0;
        else        level_d_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~level_d_q;

    // R2
    // a rising flag is followed by the settled level still being high
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> level_d_q);
endmodule

// File: rtl/pwrup_timer.sv
// Power-up window timer. A load pulse starts a window of PULSE_CYCLES
// cycles, during which active_o is high. A new load restarts the window.
// Assumes PULSE_CYCLES >= 1.
module pwrup_timer #(
    parameter int PULSE_CYCLES = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on launch, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load_i)        cnt_q <= CNT_LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

    // R2
    // the window counter never exceeds its load value
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

    // R10
    // the counter only grows on an accepted launch
    pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> $past(load_i));
endmodule

// File: rtl/conv_ctrl.sv
// Conversion controller. Arms on an accepted pin rise and starts a
// conversion once neither the pin nor the power-up window is high. While
// busy, it waits for the core's done strobe. On done, it latches the result
// and picks the power mode from the pin level.
// Assumes the pin inputs are already synchronous to clk.
module conv_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_lvl_i,
    input  logic             pin_rise_i,
    input  logic             window_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] core_result_i,
    output logic             launch_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             pwrdn_o,
    output logic [RES_W-1:0] result_o
);
    seq_state_t state_q;
    logic       start_gate;

    // A pin rise is accepted in any state except while converting.
    assign launch_o   = pin_rise_i && (state_q != ST_BUSY);
    // Combined start request: pin OR power-up window.
    assign start_gate = pin_lvl_i | window_i;

    // Sequence launch, start and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (launch_o)    state_q <= ST_ARMED;
                ST_ARMED: if (!start_gate) state_q <= ST_BUSY;
                ST_BUSY:  if (done_i)      state_q <= ST_IDLE;
                default:                   state_q <= ST_IDLE;
            endcase
        end
    end

    // Emit the one-cycle hold strobe as the conversion begins.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_o <= 1'b0;
        else        hold_o <= (state_q == ST_ARMED) && !start_gate;
    end

    // Pick the power mode at the end of a conversion; wake on launch.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pwrdn_o <= 1'b0;
        else if (state_q == ST_BUSY && done_i)   pwrdn_o <= ~pin_lvl_i;
        else if (launch_o)                       pwrdn_o <= 1'b0;
    end

    // Capture the core's value at the end of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                              result_o <= '0;
        else if (state_q == ST_BUSY && done_i)   result_o <= core_result_i;
    end

    assign busy_o = (state_q == ST_BUSY);

    // R4
    // the hold strobe coincides with the first busy cycle
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (busy_o && !$past(busy_o)));

    // R5
    // busy only falls after a done strobe
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_i));

    // R7
    // power-down is entered only as a conversion ends
    pwrdn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrdn_o) |-> $fell(busy_o));

    // R9
    // the result register is stable except when a conversion ends
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> $stable(result_o));

    // R6
    // never converting while powered down
    pwrdn_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwrdn_o && busy_o));
endmodule

// File: rtl/adc_start_sequencer.sv
// Top of the convert-start and power-down sequencer. Connects the pin
// synchroniser, the power-up window timer and the conversion controller.
// Assumes conv_done_i is a one-cycle strobe synchronous to clk and that
// core_result_i is valid in the cycle the strobe is high.
module adc_start_sequencer #(
    parameter int PULSE_CYCLES = 150,
    parameter int RES_W        = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             convst_i,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] core_result_i,
    output logic             hold_o,
    output logic             busy_o,
    output logic             pwrdn_o,
    output logic [RES_W-1:0] result_o
);
    logic pin_lvl;
    logic pin_rise;
    logic launch;
    logic window;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (convst_i),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    pwrup_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (launch),
        .active_o (window)
    );

    conv_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_lvl_i     (pin_lvl),
        .pin_rise_i    (pin_rise),
        .window_i      (window),
        .done_i        (conv_done_i),
        .core_result_i (core_result_i),
        .launch_o      (launch),
        .hold_o        (hold_o),
        .busy_o        (busy_o),
        .pwrdn_o       (pwrdn_o),
        .result_o      (result_o)
    );

    // R10
    // no launch is ever accepted while a conversion runs
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !launch);
endmodule

// File: tb/tb_adc_start_sequencer.sv
module tb_adc_start_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 16;
    localparam int RW         = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          convst = 1'b0;
    logic          done = 1'b0;
    logic [RW-1:0] core_res = '0;
    logic          hold, busy, pwrdn;
    logic [RW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [RW-1:0] exp_result = '0;

    adc_start_sequencer #(.PULSE_CYCLES(P), .RES_W(RW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .convst_i(convst), .conv_done_i(done),
        .core_result_i(core_res), .hold_o(hold), .busy_o(busy),
        .pwrdn_o(pwrdn), .result_o(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            report();
        end
    end

    // Edge on which busy is due after a pin held high for w edges (R2/R3).
    function automatic int exp_latency(input int w);
        return ((w > P + 1) ? w : P + 1) + 3;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Launch with pin high for w edges, then complete a conversion.
    task automatic convert(input int w, input logic pin_at_done, input int dly,
                           input logic [RW-1:0] val, input logic was_pwrdn);
        int cnt = 0;
        int seen = -1;
        string tag;
        convst = 1'b1;
        while (seen < 0 && cnt < w + P + 20) begin
            @(negedge clk);
            cnt++;
            if (was_pwrdn && cnt == 2) check(pwrdn == 1'b1, "R8", pwrdn, 1);
            if (was_pwrdn && cnt == 3) check(pwrdn == 1'b0, "R8", pwrdn, 0);
            if (busy) seen = cnt;
            else if (cnt < exp_latency(w)) check(hold == 1'b0, "R4", hold, 0);
            if (cnt == w) convst = 1'b0;
        end
        tag = (w > P) ? "R3" : "R2";
        check(seen == exp_latency(w), tag, seen, exp_latency(w));
        check(hold == 1'b1, "R4", hold, 1);
        // A rise while busy must be ignored (R10).
        if (pin_at_done) convst = 1'b1;
        @(negedge clk);
        check(hold == 1'b0 && busy == 1'b1, "R4", {hold, busy}, 1);
        idle(dly + 4);
        check(busy == 1'b1, "R5", busy, 1);
        check(result == exp_result, "R9", result, exp_result);
        done = 1'b1; core_res = val;
        @(negedge clk);
        done = 1'b0; core_res = ~val;
        exp_result = val;
        check(busy == 1'b0, "R5", busy, 0);
        check(result == val, "R5", result, val);
        if (pin_at_done) check(pwrdn == 1'b0, "R6", pwrdn, 0);
        else             check(pwrdn == 1'b1, "R7", pwrdn, 1);
        // No restart from the ignored rise (R10), result held (R9).
        for (int i = 0; i < P + 6; i++) begin
            @(negedge clk);
            if (busy || hold) check(1'b0, "R10", busy, 0);
        end
        check(result == val, "R9", result, val);
        if (pin_at_done) begin
            convst = 1'b0;
            idle(P + 6);
            check(busy == 1'b0, "R11", busy, 0);
        end
    endtask

    initial begin
        logic pd;
        void'($urandom(32'd20240611));
        idle(3);
        check(busy == 1'b0 && hold == 1'b0 && pwrdn == 1'b0, "R1", {busy, hold, pwrdn}, 0);
        check(result == '0, "R1", result, 0);
        @(negedge clk) rst_n = 1'b1;
        idle(4);
        // Pin fall with no prior accepted launch.
        convst = 1'b0; idle(P + 6);
        check(busy == 1'b0, "R11", busy, 0);
        // Directed corners: narrow pin, pin exactly window, wide pin.
        pd = 1'b0;
        convert(1, 1'b0, 2, 10'h3A5, pd);      pd = 1'b1;
        // done while powered down is ignored (R9)
        done = 1'b1; core_res = 10'h111;
        @(negedge clk) done = 1'b0;
        idle(2);
        check(result == exp_result, "R9", result, exp_result);
        check(pwrdn == 1'b1 && busy == 1'b0, "R9", {pwrdn, busy}, 2);
        convert(P, 1'b1, 3, 10'h05A, pd);      pd = 1'b0;
        convert(P + 1, 1'b1, 0, 10'h3FF, pd);  pd = 1'b0;
        convert(P + 9, 1'b0, 5, 10'h000, pd);  pd = 1'b1;
        // Random mix.
        for (int k = 0; k < 40; k++) begin
            int w = 1 + int'($urandom_range(P + 8));
            logic hs = logic'($urandom_range(1));
            int d = int'($urandom_range(12));
            logic [RW-1:0] v = RW'($urandom);
            convert(w, hs, d, v, pd);
            pd = ~hs;
        end
        report();
    end
endmodule